// File: doc/BRIEF.md
# Inter-Core Stride Miss Detector

This block looks at translation misses from several cores and finds the ones that follow a fixed page stride. A new miss qualifies when its virtual page is a known number of pages away from a recent miss on a different core. Each core has its own lane. In every cycle a lane may offer one miss: a context ID, a virtual page number, a page-size code and a global instruction count. The offered miss is compared, for every candidate stride at once, against a history of recent misses. It is also compared against same-cycle misses on lanes with a lower index. One cycle later the lane reports whether it found a match. On a match it also reports the chosen signed stride and the servicing core, which is the core whose earlier miss the stride is measured from. The requesting core is the lane index.

The candidate strides sit in a small register file that is written through a one-slot write port. A slot holding zero is disabled. A matrix of saturating counters, one per ordered pair of requesting core and servicing core, records every reported match. Any one counter can be read combinationally through a select port. Only misses that are not already exact repeats of another core's miss should be offered. Issuing prefetches or fills is left to the logic outside.

Top module: `stride_miss_detector`

## Requirements
- R1: After reset every `hit_o` bit is 0 and every coverage counter reads 0.
- R2: A miss offered on lane j in cycle t raises `hit_o[j]` in cycle t+1, with stride S and servicer i, when a stored earlier miss from core i (i != j) has the same context ID, the same page-size code and a virtual page V such that the new virtual page equals V+S modulo 2^VPN_W. Strides are two's-complement with STRIDE_W bits; `hit_stride_o` lane j occupies bits [j*STRIDE_W +: STRIDE_W] and `hit_srv_o` lane j occupies bits [j*CORE_W +: CORE_W].
- R3: A difference in context ID or in page-size code prevents a match.
- R4: A match also requires the new instruction count minus the stored one, as an unsigned ICNT_W-bit difference, to be below WINDOW. A difference equal to WINDOW gives no match.
- R5: A miss never matches an earlier miss from its own core.
- R6: When several strides match, the one with the smallest magnitude is reported. When a positive and a negative stride have the same magnitude, the positive one is reported.
- R7: When several cores match at the reported stride, the lowest core index is reported as servicer.
- R8: Misses offered in the same cycle are ordered by lane index. A lane matches same-cycle misses on lower-index lanes and never those on higher-index lanes.
- R9: Candidate slots reset to +1, -1, +2, -2, +3, -3, +4, -4 for slots 0 to 7 (slot k has magnitude k/2+1 and is negative when k is odd). Asserting `cfg_we_i` writes `cfg_stride_i` into slot `cfg_idx_i`. A slot holding 0 never matches.
- R10: Each reported match adds one to the counter for its (requester, servicer) pair, which is read on `cov_count_o` when selected by `cov_req_i`/`cov_srv_i`. Counters stop at 2^CNT_W-1.
- R11: The history keeps the last HIST_DEPTH offered misses. A miss followed by HIST_DEPTH newer misses can no longer be matched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_valid_i | input | NUM_CORES | One bit per lane: a miss is offered this cycle |
| miss_ctx_i | input | NUM_CORES*CTX_W | Context ID of each lane's miss |
| miss_vpn_i | input | NUM_CORES*VPN_W | Virtual page number of each lane's miss |
| miss_psz_i | input | NUM_CORES*PSZ_W | Page-size code of each lane's miss |
| miss_icnt_i | input | NUM_CORES*ICNT_W | Global instruction count when each miss occurred |
| cfg_we_i | input | 1 | Write enable for the candidate stride slots |
| cfg_idx_i | input | SIDX_W | Slot written |
| cfg_stride_i | input | STRIDE_W | Signed stride value written |
| hit_o | output | NUM_CORES | Per lane: a stride match was found for last cycle's miss |
| hit_stride_o | output | NUM_CORES*STRIDE_W | Per lane: the reported signed stride |
| hit_srv_o | output | NUM_CORES*CORE_W | Per lane: the reported servicing core |
| cov_req_i | input | CORE_W | Requester row of the counter to read |
| cov_srv_i | input | CORE_W | Servicer column of the counter to read |
| cov_count_o | output | CNT_W | Selected coverage counter |

## Verification
The checks assume several things about the inputs. Instruction counts grow, or at least do not fall, over the misses offered within one context. Virtual pages stay clear of the top and bottom of the page-number range, so the modular sum agrees with plain arithmetic. Stride slots are rewritten only in cycles when no lane offers a miss. Any counter-step property needs the read select held for at least two cycles. The stimulus gives each scenario a context ID of its own, so entries from earlier scenarios cannot produce matches. It moves instruction counts forward by ten per cycle, except in the window case, which uses explicit values right at the limit. It keeps all pages in the low thousands and writes configuration only on idle cycles.

// File: rtl/smd_pkg.sv
package smd_pkg;
  parameter int CTX_W    = 8;
  parameter int VPN_W    = 24;
  parameter int PSZ_W    = 2;
  parameter int ICNT_W   = 32;
  parameter int STRIDE_W = 6;

  typedef struct packed {
    logic [CTX_W-1:0]  ctx;
    logic [VPN_W-1:0]  vpn;
    logic [PSZ_W-1:0]  psz;
    logic [ICNT_W-1:0] icnt;
  } miss_t;

  function automatic logic [STRIDE_W-1:0] default_stride(int k);
    int mag;
    mag = k / 2 + 1;
    return (k % 2 == 1) ? STRIDE_W'(-mag) : STRIDE_W'(mag);
  endfunction

  // smaller magnitude wins, positive wins a tie
  function automatic logic stride_better(logic [STRIDE_W-1:0] a, logic [STRIDE_W-1:0] b);
    logic [STRIDE_W-1:0] ma, mb;
    ma = a[STRIDE_W-1] ? -a : a;
    mb = b[STRIDE_W-1] ? -b : b;
    return (ma < mb) || ((ma == mb) && !a[STRIDE_W-1] && b[STRIDE_W-1]);
  endfunction
endpackage

// File: rtl/stride_cfg_regs.sv
module stride_cfg_regs
  import smd_pkg::*;
#(
  parameter int NUM_STRIDES = 8,
  parameter int SIDX_W      = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [SIDX_W-1:0]   idx_i,
  input  logic [STRIDE_W-1:0] stride_i,
  output logic [STRIDE_W-1:0] slots_o [NUM_STRIDES]
);
  logic [STRIDE_W-1:0] slots_q [NUM_STRIDES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NUM_STRIDES; k++) slots_q[k] <= default_stride(k);
    end else if (we_i && (32'(idx_i) < NUM_STRIDES)) begin
      slots_q[idx_i] <= stride_i;
    end
  end

  assign slots_o = slots_q;
endmodule

// File: rtl/miss_history.sv
module miss_history
  import smd_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int DEPTH     = 32,
  parameter int CORE_W    = 2,
  parameter int HIDX_W    = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_CORES-1:0] in_valid_i,
  input  miss_t                in_miss_i [NUM_CORES],
  output logic [DEPTH-1:0]     ent_valid_o,
  output logic [CORE_W-1:0]    ent_core_o [DEPTH],
  output miss_t                ent_miss_o [DEPTH]
);
  logic [HIDX_W-1:0] wp_q, wp_d;
  logic [HIDX_W-1:0] slot [NUM_CORES];
  logic [DEPTH-1:0]  valid_q;
  logic [CORE_W-1:0] core_q [DEPTH];
  miss_t             miss_q [DEPTH];

  // lanes take consecutive slots in index order
  always_comb begin
    logic [HIDX_W-1:0] cnt;
    cnt = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      slot[c] = wp_q + cnt;
      cnt     = cnt + HIDX_W'(in_valid_i[c]);
    end
    wp_d = wp_q + cnt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q    <= '0;
      valid_q <= '0;
    end else begin
      wp_q <= wp_d;
      for (int c = 0; c < NUM_CORES; c++)
        if (in_valid_i[c]) valid_q[slot[c]] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    for (int c = 0; c < NUM_CORES; c++) begin
      if (in_valid_i[c]) begin
        core_q[slot[c]] <= CORE_W'(c);
        miss_q[slot[c]] <= in_miss_i[c];
      end
    end
  end

  assign ent_valid_o = valid_q;
  assign ent_core_o  = core_q;
  assign ent_miss_o  = miss_q;
endmodule

// File: rtl/stride_lane_match.sv
module stride_lane_match
  import smd_pkg::*;
#(
  parameter int LANE        = 0,
  parameter int NUM_CORES   = 4,
  parameter int DEPTH       = 32,
  parameter int NUM_STRIDES = 8,
  parameter int WINDOW      = 1000000,
  parameter int CORE_W      = 2,
  parameter int SIDX_W      = 3
) (
  input  logic                 own_valid_i,
  input  miss_t                own_miss_i,
  input  logic [DEPTH-1:0]     ent_valid_i,
  input  logic [CORE_W-1:0]    ent_core_i [DEPTH],
  input  miss_t                ent_miss_i [DEPTH],
  input  logic [NUM_CORES-1:0] lane_valid_i,
  input  miss_t                lane_miss_i [NUM_CORES],
  input  logic [STRIDE_W-1:0]  strides_i [NUM_STRIDES],
  output logic                 hit_o,
  output logic [STRIDE_W-1:0]  stride_o,
  output logic [CORE_W-1:0]    srv_o
);
  logic [NUM_STRIDES-1:0][NUM_CORES-1:0] m;
  logic [SIDX_W-1:0] best;
  logic              found;

  function automatic logic pair_ok(miss_t j, miss_t i, logic [STRIDE_W-1:0] s);
    logic [ICNT_W-1:0] age;
    age = j.icnt - i.icnt;
    return (s != '0) && (j.ctx == i.ctx) && (j.psz == i.psz) &&
           (j.vpn == i.vpn + VPN_W'($signed(s))) && (age < ICNT_W'(WINDOW));
  endfunction

  always_comb begin
    m = '0;
    for (int s = 0; s < NUM_STRIDES; s++) begin
      for (int d = 0; d < DEPTH; d++)
        if (ent_valid_i[d] && (ent_core_i[d] != CORE_W'(LANE)) &&
            pair_ok(own_miss_i, ent_miss_i[d], strides_i[s]))
          m[s][ent_core_i[d]] = 1'b1;
      // same-cycle arrivals: only lower lanes count as earlier
      for (int k = 0; k < LANE; k++)
        if (lane_valid_i[k] && pair_ok(own_miss_i, lane_miss_i[k], strides_i[s]))
          m[s][k] = 1'b1;
    end
  end

  always_comb begin
    found = 1'b0;
    best  = '0;
    for (int s = 0; s < NUM_STRIDES; s++) begin
      if ((|m[s]) && (!found || stride_better(strides_i[s], strides_i[best]))) begin
        best  = SIDX_W'(s);
        found = 1'b1;
      end
    end
    srv_o = '0;
    for (int k = NUM_CORES - 1; k >= 0; k--)
      if (m[best][k]) srv_o = CORE_W'(k);
  end

  assign hit_o    = own_valid_i && found;
  assign stride_o = strides_i[best];
endmodule

// File: rtl/coverage_matrix.sv
module coverage_matrix #(
  parameter int NUM_CORES = 4,
  parameter int CNT_W     = 16,
  parameter int CORE_W    = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_CORES-1:0] hit_i,
  input  logic [CORE_W-1:0]    srv_i [NUM_CORES],
  input  logic [CORE_W-1:0]    rd_req_i,
  input  logic [CORE_W-1:0]    rd_srv_i,
  output logic [CNT_W-1:0]     count_o
);
  logic [CNT_W-1:0] cnt_q [NUM_CORES][NUM_CORES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NUM_CORES; r++)
        for (int s = 0; s < NUM_CORES; s++) cnt_q[r][s] <= '0;
    end else begin
      for (int r = 0; r < NUM_CORES; r++)
        for (int s = 0; s < NUM_CORES; s++)
          if (hit_i[r] && (srv_i[r] == CORE_W'(s)) && (cnt_q[r][s] != '1))
            cnt_q[r][s] <= cnt_q[r][s] + 1'b1;
    end
  end

  assign count_o = cnt_q[rd_req_i][rd_srv_i];
endmodule

// File: rtl/stride_miss_detector.sv
module stride_miss_detector
  import smd_pkg::*;
#(
  parameter int NUM_CORES   = 4,
  parameter int HIST_DEPTH  = 32,
  parameter int NUM_STRIDES = 8,
  parameter int WINDOW      = 1000000,
  parameter int CNT_W       = 16,
  localparam int CORE_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int SIDX_W     = (NUM_STRIDES > 1) ? $clog2(NUM_STRIDES) : 1,
  localparam int HIDX_W     = (HIST_DEPTH > 1) ? $clog2(HIST_DEPTH) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_CORES-1:0]          miss_valid_i,
  input  logic [NUM_CORES*CTX_W-1:0]    miss_ctx_i,
  input  logic [NUM_CORES*VPN_W-1:0]    miss_vpn_i,
  input  logic [NUM_CORES*PSZ_W-1:0]    miss_psz_i,
  input  logic [NUM_CORES*ICNT_W-1:0]   miss_icnt_i,
  input  logic                          cfg_we_i,
  input  logic [SIDX_W-1:0]             cfg_idx_i,
  input  logic [STRIDE_W-1:0]           cfg_stride_i,
  output logic [NUM_CORES-1:0]          hit_o,
  output logic [NUM_CORES*STRIDE_W-1:0] hit_stride_o,
  output logic [NUM_CORES*CORE_W-1:0]   hit_srv_o,
  input  logic [CORE_W-1:0]             cov_req_i,
  input  logic [CORE_W-1:0]             cov_srv_i,
  output logic [CNT_W-1:0]              cov_count_o
);
  miss_t               lane_miss [NUM_CORES];
  logic [STRIDE_W-1:0] strides [NUM_STRIDES];
  logic [HIST_DEPTH-1:0] ent_valid;
  logic [CORE_W-1:0]   ent_core [HIST_DEPTH];
  miss_t               ent_miss [HIST_DEPTH];
  logic [NUM_CORES-1:0] lane_hit;
  logic [STRIDE_W-1:0] lane_stride [NUM_CORES];
  logic [CORE_W-1:0]   lane_srv [NUM_CORES];
  logic [NUM_CORES-1:0] hit_q;
  logic [STRIDE_W-1:0] stride_q [NUM_CORES];
  logic [CORE_W-1:0]   srv_q [NUM_CORES];

  stride_cfg_regs #(.NUM_STRIDES(NUM_STRIDES), .SIDX_W(SIDX_W)) i_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .idx_i(cfg_idx_i),
    .stride_i(cfg_stride_i), .slots_o(strides)
  );

  miss_history #(.NUM_CORES(NUM_CORES), .DEPTH(HIST_DEPTH),
                 .CORE_W(CORE_W), .HIDX_W(HIDX_W)) i_hist (
    .clk_i, .rst_ni, .in_valid_i(miss_valid_i), .in_miss_i(lane_miss),
    .ent_valid_o(ent_valid), .ent_core_o(ent_core), .ent_miss_o(ent_miss)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_lane
    assign lane_miss[c].ctx  = miss_ctx_i[c*CTX_W +: CTX_W];
    assign lane_miss[c].vpn  = miss_vpn_i[c*VPN_W +: VPN_W];
    assign lane_miss[c].psz  = miss_psz_i[c*PSZ_W +: PSZ_W];
    assign lane_miss[c].icnt = miss_icnt_i[c*ICNT_W +: ICNT_W];

    stride_lane_match #(.LANE(c), .NUM_CORES(NUM_CORES), .DEPTH(HIST_DEPTH),
                        .NUM_STRIDES(NUM_STRIDES), .WINDOW(WINDOW),
                        .CORE_W(CORE_W), .SIDX_W(SIDX_W)) i_match (
      .own_valid_i(miss_valid_i[c]), .own_miss_i(lane_miss[c]),
      .ent_valid_i(ent_valid), .ent_core_i(ent_core), .ent_miss_i(ent_miss),
      .lane_valid_i(miss_valid_i), .lane_miss_i(lane_miss),
      .strides_i(strides), .hit_o(lane_hit[c]),
      .stride_o(lane_stride[c]), .srv_o(lane_srv[c])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hit_q[c]    <= 1'b0;
        stride_q[c] <= '0;
        srv_q[c]    <= '0;
      end else begin
        hit_q[c]    <= lane_hit[c];
        stride_q[c] <= lane_stride[c];
        srv_q[c]    <= lane_srv[c];
      end
    end

    assign hit_stride_o[c*STRIDE_W +: STRIDE_W] = stride_q[c];
    assign hit_srv_o[c*CORE_W +: CORE_W]        = srv_q[c];
  end

  assign hit_o = hit_q;

  coverage_matrix #(.NUM_CORES(NUM_CORES), .CNT_W(CNT_W), .CORE_W(CORE_W)) i_cov (
    .clk_i, .rst_ni, .hit_i(lane_hit), .srv_i(lane_srv),
    .rd_req_i(cov_req_i), .rd_srv_i(cov_srv_i), .count_o(cov_count_o)
  );
endmodule

// File: rtl/stride_miss_checker.sv
module stride_miss_checker
  import smd_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CNT_W     = 16,
  parameter int CORE_W    = 2
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [NUM_CORES-1:0]          miss_valid_i,
  input logic [NUM_CORES-1:0]          hit_o,
  input logic [NUM_CORES*STRIDE_W-1:0] hit_stride_o,
  input logic [NUM_CORES*CORE_W-1:0]   hit_srv_o,
  input logic [CORE_W-1:0]             cov_req_i,
  input logic [CORE_W-1:0]             cov_srv_i,
  input logic [CNT_W-1:0]              cov_count_o
);
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
    // R2
    hit_after_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_o[c] |-> $past(miss_valid_i[c]));
    // R5
    srv_not_self_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_o[c] |-> (hit_srv_o[c*CORE_W +: CORE_W] != CORE_W'(c)));
    // R9
    stride_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_o[c] |-> (hit_stride_o[c*STRIDE_W +: STRIDE_W] != '0));
  end

  // R10
  cov_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(cov_req_i) && $stable(cov_srv_i)) |->
      ((cov_count_o == $past(cov_count_o)) || (cov_count_o == $past(cov_count_o) + 1'b1)));
endmodule

bind stride_miss_detector stride_miss_checker #(
  .NUM_CORES(NUM_CORES), .CNT_W(CNT_W), .CORE_W(CORE_W)
) i_stride_miss_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .miss_valid_i(miss_valid_i), .hit_o(hit_o),
  .hit_stride_o(hit_stride_o), .hit_srv_o(hit_srv_o), .cov_req_i(cov_req_i),
  .cov_srv_i(cov_srv_i), .cov_count_o(cov_count_o)
);

// File: tb/test_stride_miss_detector.sv
module test_stride_miss_detector;
  import smd_pkg::*;
  timeunit 1ns; timeprecision 1ps;

  localparam int NC = 4, NS = 8, DEPTH = 32, CNTW = 4, WIN = 1000000;
  localparam int CW = 2, SW = 3, CMAX = 15;

  logic clk_i = 1'b0;
  always #10 clk_i = ~clk_i;

  logic rst_ni;
  logic [NC-1:0]          miss_valid;
  logic [NC*CTX_W-1:0]    miss_ctx;
  logic [NC*VPN_W-1:0]    miss_vpn;
  logic [NC*PSZ_W-1:0]    miss_psz;
  logic [NC*ICNT_W-1:0]   miss_icnt;
  logic                   cfg_we;
  logic [SW-1:0]          cfg_idx;
  logic [STRIDE_W-1:0]    cfg_stride;
  logic [NC-1:0]          hit_o;
  logic [NC*STRIDE_W-1:0] hit_stride_o;
  logic [NC*CW-1:0]       hit_srv_o;
  logic [CW-1:0]          cov_req, cov_srv;
  logic [CNTW-1:0]        cov_count;

  stride_miss_detector #(.NUM_CORES(NC), .HIST_DEPTH(DEPTH), .NUM_STRIDES(NS),
                         .WINDOW(WIN), .CNT_W(CNTW)) i_stride_miss_detector (
    .clk_i, .rst_ni, .miss_valid_i(miss_valid), .miss_ctx_i(miss_ctx),
    .miss_vpn_i(miss_vpn), .miss_psz_i(miss_psz), .miss_icnt_i(miss_icnt),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_stride_i(cfg_stride),
    .hit_o, .hit_stride_o, .hit_srv_o, .cov_req_i(cov_req), .cov_srv_i(cov_srv),
    .cov_count_o(cov_count)
  );

  int n_tests = 0, n_fail = 0, tnow = 100;
  int exp_cov [NC][NC];
  bit done = 0;

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_lane(int c, int ctx, int vpn, int psz, int icnt);
    miss_valid[c] = 1'b1;
    miss_ctx[c*CTX_W +: CTX_W]    = CTX_W'(ctx);
    miss_vpn[c*VPN_W +: VPN_W]    = VPN_W'(vpn);
    miss_psz[c*PSZ_W +: PSZ_W]    = PSZ_W'(psz);
    miss_icnt[c*ICNT_W +: ICNT_W] = ICNT_W'(icnt);
  endtask

  task automatic fire();
    @(posedge clk_i);
    @(negedge clk_i);
    miss_valid = '0;
    tnow += 10;
  endtask

  task automatic chk_lane(string req, int c, bit eh, int es, int esrv);
    chk(req, $sformatf("lane%0d hit", c), int'(hit_o[c]), int'(eh));
    if (eh) begin
      chk(req, $sformatf("lane%0d stride", c),
          int'($signed(hit_stride_o[c*STRIDE_W +: STRIDE_W])), es);
      chk(req, $sformatf("lane%0d servicer", c), int'(hit_srv_o[c*CW +: CW]), esrv);
      if (hit_o[c] && exp_cov[c][esrv] < CMAX) exp_cov[c][esrv]++;
    end
  endtask

  task automatic cov_read(int r, int s, output int v);
    cov_req = CW'(r); cov_srv = CW'(s);
    #1 v = int'(cov_count);
  endtask

  task automatic cfg_write(int idx, int val);
    cfg_we = 1'b1; cfg_idx = SW'(idx); cfg_stride = STRIDE_W'(val);
    @(posedge clk_i);
    @(negedge clk_i);
    cfg_we = 1'b0;
  endtask

  task automatic t_reset();
    int v;
    chk("R1", "hit_o after reset", int'(hit_o), 0);
    for (int r = 0; r < NC; r++)
      for (int s = 0; s < NC; s++) begin
        cov_read(r, s, v);
        chk("R1", $sformatf("cov[%0d][%0d]", r, s), v, 0);
      end
  endtask

  task automatic t_basic();
    set_lane(0, 2, 100, 1, tnow); fire(); chk_lane("R2", 0, 0, 0, 0);
    set_lane(1, 2, 101, 1, tnow); fire(); chk_lane("R2", 1, 1, 1, 0);
    // -3 from core0 beats -4 from core1; default slots hold both (R9)
    set_lane(2, 2, 97, 1, tnow); fire(); chk_lane("R6 R9", 2, 1, -3, 0);
  endtask

  task automatic t_mismatch();
    set_lane(0, 3, 200, 0, tnow); fire();
    set_lane(1, 4, 201, 0, tnow); fire(); chk_lane("R3 ctx", 1, 0, 0, 0);
    set_lane(1, 3, 201, 1, tnow); fire(); chk_lane("R3 psz", 1, 0, 0, 0);
    set_lane(1, 3, 201, 0, tnow); fire(); chk_lane("R3 control", 1, 1, 1, 0);
  endtask

  task automatic t_window();
    set_lane(0, 5, 300, 1, 5000); fire();
    set_lane(1, 5, 301, 1, 5000 + WIN); fire(); chk_lane("R4 at limit", 1, 0, 0, 0);
    set_lane(2, 5, 301, 1, 5000 + WIN - 1); fire(); chk_lane("R4 inside", 2, 1, 1, 0);
  endtask

  task automatic t_same_core();
    set_lane(3, 6, 400, 0, tnow); fire();
    set_lane(3, 6, 401, 0, tnow); fire(); chk_lane("R5", 3, 0, 0, 0);
  endtask

  task automatic t_priority();
    set_lane(0, 7, 500, 0, tnow); fire();
    set_lane(1, 7, 504, 0, tnow); fire();
    set_lane(2, 7, 502, 0, tnow); fire(); chk_lane("R6 tie", 2, 1, 2, 0);
    set_lane(3, 8, 600, 0, tnow); fire();
    set_lane(1, 8, 600, 0, tnow); fire();
    set_lane(2, 8, 601, 0, tnow); fire(); chk_lane("R7", 2, 1, 1, 1);
  endtask

  task automatic t_same_cycle();
    set_lane(0, 9, 700, 0, tnow);
    set_lane(1, 9, 701, 0, tnow);
    set_lane(2, 9, 699, 0, tnow);
    set_lane(3, 9, 702, 0, tnow);
    fire();
    chk_lane("R8", 0, 0, 0, 0);
    chk_lane("R8", 1, 1, 1, 0);
    chk_lane("R8", 2, 1, -1, 0);
    chk_lane("R8", 3, 1, 1, 1);
  endtask

  task automatic t_config();
    cfg_write(0, 0);
    set_lane(0, 10, 800, 0, tnow); fire();
    set_lane(1, 10, 801, 0, tnow); fire(); chk_lane("R9 zero slot", 1, 0, 0, 0);
    cfg_write(0, 5);
    set_lane(0, 10, 810, 0, tnow); fire();
    set_lane(1, 10, 815, 0, tnow); fire(); chk_lane("R9 written", 1, 1, 5, 0);
    cfg_write(0, 1);
  endtask

  task automatic t_saturate();
    int v;
    for (int it = 0; it < 20; it++) begin
      set_lane(0, 11, 1000, 0, tnow);
      set_lane(1, 11, 1001, 0, tnow);
      fire();
      chk_lane("R10", 0, (it > 0), -1, 1);
      chk_lane("R10", 1, 1, 1, 0);
    end
    cov_read(1, 0, v);
    chk("R10", "saturated cov[1][0]", v, CMAX);
  endtask

  task automatic t_depth();
    set_lane(0, 12, 2000, 0, tnow); fire();
    for (int i = 0; i < DEPTH - 1; i++) begin set_lane(1, 13, 3000 + i, 0, tnow); fire(); end
    set_lane(2, 12, 2001, 0, tnow); fire(); chk_lane("R11 kept", 2, 1, 1, 0);
    set_lane(0, 12, 2100, 0, tnow); fire();
    for (int i = 0; i < DEPTH; i++) begin set_lane(1, 13, 3100 + i, 0, tnow); fire(); end
    set_lane(2, 12, 2101, 0, tnow); fire(); chk_lane("R11 evicted", 2, 0, 0, 0);
  endtask

  task automatic t_cov_all();
    int v;
    for (int r = 0; r < NC; r++)
      for (int s = 0; s < NC; s++) begin
        cov_read(r, s, v);
        chk("R10", $sformatf("cov[%0d][%0d]", r, s), v, exp_cov[r][s]);
      end
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < NC; r++) for (int s = 0; s < NC; s++) exp_cov[r][s] = 0;
    rst_ni = 1'b0; miss_valid = '0; miss_ctx = '0; miss_vpn = '0; miss_psz = '0;
    miss_icnt = '0; cfg_we = 1'b0; cfg_idx = '0; cfg_stride = '0;
    cov_req = '0; cov_srv = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_basic();
    t_mismatch();
    t_window();
    t_same_core();
    t_priority();
    t_same_cycle();
    t_config();
    t_saturate();
    t_depth();
    t_cov_all();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule